// File: doc/BRIEF.md
# Queued-Duty Pulse Width Modulator

This block produces one pulse-width-modulated output under the control of a small word-addressed register bank. Software programs a period and a prescale factor, then feeds duty values into a four-entry queue. The period counter takes the next queued duty value at the end of a period. Each duty value can be held for one, two, four or eight consecutive periods before the next one is taken, so software can stream a waveform with few writes.

A single clock-enable input stands in for the selected counting clock. A control field gates it, and a 12-bit prescaler divides it. Status reports the queue depth and three sticky events. A self-clearing software reset returns the whole block to its defaults.

Top module: `pwmq_unit`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (status), 0x0C (sample) and 0x10 (period). The control fields are: bit 0 run, bits 2:1 repeat code, bit 3 software reset, bits 15:4 prescale minus one, bits 17:16 count source, bits 19:18 output mode. Reads return the stored fields. Other addresses read 0.
- R2: One output period lasts (period value + 2) prescaled ticks. The counter runs from 0 up to period + 1 and then returns to 0. A stored period of 0xFFFF acts exactly like 0xFFFE but reads back as written.
- R3: Output mode 0 drives high while the counter is below the active duty value and low otherwise. Mode 1 is the inverse of mode 0. Modes 2 and 3 hold the output low.
- R4: While the run bit is 0 the output is 0, whatever the output mode.
- R5: A prescaled tick occurs on every (prescale field + 1)-th cycle that has tick_en high. No ticks occur while the count source field is 0.
- R6: Sample writes enter a 4-deep queue. Status bits 2:0 hold the number of queued words (0 to 4). Status bit 3 is 1 exactly when the queue is empty.
- R7: A sample write to a full queue is dropped and sets sticky status bit 6.
- R8: Writing control with bit 3 set resets every register, flag and the queue. Control bit 3 then reads 1 for RST_CYCLES cycles and clears itself. Bus writes are ignored during that time.
- R9: A sample read returns the active duty value while running, and 0 while stopped.
- R10: At a period end, once the active value has been used for 2^repeat periods, the next queued word becomes active. If the queue is empty, the active value is kept.
- R11: Status bit 4 (period end) and bit 5 (tick while the counter equals the duty value) are sticky. Bits 4, 5 and 6 are cleared by writing 1 to them. A new event in the same cycle wins over the clear.
- R12: A control write that sets run while stopped restarts the counter from 0 and at once takes the first queued word, if there is one, as the active value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count clock enable strobe |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest case to reach is a period end that pops the queue in the same cycle as a sample write arrives at a full queue. The repeat counter must also be on its last use when this happens, since that is when the full check and the pop meet. The stimulus keeps the queue topped up while the short periods and the repeat codes cycle. This brings period ends against writes on many different cycles. The bench also runs one period at the saturated top code, long enough to see the wrap at 0xFFFF.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_STAT = 4;
  localparam int unsigned OFS_SAMP = 12;
  localparam int unsigned OFS_PER  = 16;

  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_RPT  = 1;
  localparam int unsigned CB_SWR  = 3;
  localparam int unsigned CB_PSC  = 4;
  localparam int unsigned CB_SRC  = 16;
  localparam int unsigned CB_MODE = 18;

  localparam int unsigned SB_EMPTY = 3;
  localparam int unsigned SB_ROLL  = 4;
  localparam int unsigned SB_CMP   = 5;
  localparam int unsigned SB_WERR  = 6;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_INVERT = 2'd1,
    MODE_OFF_A  = 2'd2,
    MODE_OFF_B  = 2'd3
  } out_mode_e;

  // The top code of a w-bit period field saturates to one below it.
  function automatic logic [31:0] clamp_top(input logic [31:0] p, input int unsigned w);
    logic [31:0] mx;
    mx = (32'd1 << w) - 32'd1;
    return (p >= mx) ? (mx - 32'd1) : p;
  endfunction

  // Index of the final period a sample is used for: 2^r - 1.
  function automatic logic [2:0] repeat_last(input logic [1:0] r);
    return 3'((4'd1 << r) - 4'd1);
  endfunction

  function automatic logic pin_level(input logic on, input logic below, input logic [1:0] mode);
    return on & ~mode[1] & (below ^ mode[0]);
  endfunction
endpackage

// File: rtl/pwmq_fifo.sv
module pwmq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      level <= level + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/pwmq_prescale.sv
module pwmq_prescale #(
  parameter int PSC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             strobe,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] pc;

  assign tick = !hold && strobe && (pc == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc <= '0;
    else if (hold)   pc <= '0;
    else if (strobe) pc <= (pc == div) ? '0 : pc + 1'b1;
  end
endmodule

// File: rtl/pwmq_counter.sv
module pwmq_counter
  import pwmq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic [CNT_W-1:0] top,
  input  logic [CNT_W-1:0] duty,
  input  logic [1:0]       rpt,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             hit,
  output logic             advance
);
  logic [2:0] rc;

  assign wrap    = tick && (cnt == top);
  assign hit     = tick && (cnt == duty);
  assign advance = wrap && (rc == repeat_last(rpt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rc  <= '0;
    end else if (hold) begin
      cnt <= '0;
      rc  <= '0;
    end else begin
      if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) rc  <= advance ? 3'd0 : rc + 3'd1;
    end
  end
endmodule

// File: rtl/pwmq_unit.sv
module pwmq_unit
  import pwmq_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int PSC_W      = 12,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam int SWR_W = $clog2(RST_CYCLES + 1);

  logic             en_q;
  logic [1:0]       rpt_q, src_q, mode_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] per_q, duty_q;
  logic             roll_q, cmp_q, werr_q;
  logic [SWR_W-1:0] swr_cnt;

  logic sel_ctrl, sel_stat, sel_samp, sel_per;
  logic swr_busy, wr_ok, swr_req, ctl_write, start_run, clr_all;
  logic samp_push, clr_roll, clr_cmp, clr_werr;
  logic [CNT_W-1:0] per_eff, top_q, cnt_q, fifo_head;
  logic [LVL_W-1:0] fifo_level;
  logic fifo_full, fifo_empty;
  logic ptick, wrap_evt, hit_evt, adv_evt, load_evt;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CB_MODE+2];

  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign sel_samp = (bus_addr == ADDR_W'(OFS_SAMP));
  assign sel_per  = (bus_addr == ADDR_W'(OFS_PER));

  assign swr_busy  = (swr_cnt != '0);
  assign wr_ok     = bus_we && !swr_busy;
  assign swr_req   = wr_ok && sel_ctrl && bus_wdata[CB_SWR];
  assign ctl_write = wr_ok && sel_ctrl && !bus_wdata[CB_SWR];
  assign start_run = ctl_write && bus_wdata[CB_RUN] && !en_q;
  assign clr_all   = swr_req || swr_busy;
  assign samp_push = wr_ok && sel_samp;
  assign clr_roll  = wr_ok && sel_stat && bus_wdata[SB_ROLL];
  assign clr_cmp   = wr_ok && sel_stat && bus_wdata[SB_CMP];
  assign clr_werr  = wr_ok && sel_stat && bus_wdata[SB_WERR];

  assign per_eff  = CNT_W'(clamp_top(32'(per_q), CNT_W));
  assign top_q    = per_eff + 1'b1;
  assign load_evt = !clr_all && !fifo_empty && (adv_evt || start_run);

  pwmq_fifo #(.DEPTH(FIFO_DEPTH), .W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(clr_all),
    .push(samp_push), .pop(load_evt), .din(bus_wdata[CNT_W-1:0]),
    .head(fifo_head), .level(fifo_level), .full(fifo_full), .empty(fifo_empty)
  );

  pwmq_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n),
    .hold(!en_q || (src_q == 2'd0) || clr_all),
    .strobe(tick_en), .div(psc_q), .tick(ptick)
  );

  pwmq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hold(!en_q || clr_all), .tick(ptick),
    .top(top_q), .duty(duty_q), .rpt(rpt_q),
    .cnt(cnt_q), .wrap(wrap_evt), .hit(hit_evt), .advance(adv_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        swr_cnt <= '0;
    else if (swr_req)  swr_cnt <= SWR_W'(RST_CYCLES);
    else if (swr_busy) swr_cnt <= swr_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; rpt_q <= '0; src_q <= '0; mode_q <= '0; psc_q <= '0;
      per_q <= '0; duty_q <= '0; roll_q <= 1'b0; cmp_q <= 1'b0; werr_q <= 1'b0;
    end else if (clr_all) begin
      en_q <= 1'b0; rpt_q <= '0; src_q <= '0; mode_q <= '0; psc_q <= '0;
      per_q <= '0; duty_q <= '0; roll_q <= 1'b0; cmp_q <= 1'b0; werr_q <= 1'b0;
    end else begin
      if (ctl_write) begin
        en_q   <= bus_wdata[CB_RUN];
        rpt_q  <= bus_wdata[CB_RPT +: 2];
        psc_q  <= bus_wdata[CB_PSC +: PSC_W];
        src_q  <= bus_wdata[CB_SRC +: 2];
        mode_q <= bus_wdata[CB_MODE +: 2];
      end
      if (wr_ok && sel_per) per_q <= bus_wdata[CNT_W-1:0];
      if (load_evt) duty_q <= fifo_head;
      roll_q <= (roll_q && !clr_roll) || wrap_evt;
      cmp_q  <= (cmp_q && !clr_cmp) || hit_evt;
      werr_q <= (werr_q && !clr_werr) || (samp_push && fifo_full);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[CB_RUN]           = en_q;
      bus_rdata[CB_RPT +: 2]      = rpt_q;
      bus_rdata[CB_SWR]           = swr_busy;
      bus_rdata[CB_PSC +: PSC_W]  = psc_q;
      bus_rdata[CB_SRC +: 2]      = src_q;
      bus_rdata[CB_MODE +: 2]     = mode_q;
    end else if (sel_stat) begin
      bus_rdata[LVL_W-1:0] = fifo_level;
      bus_rdata[SB_EMPTY]  = fifo_empty;
      bus_rdata[SB_ROLL]   = roll_q;
      bus_rdata[SB_CMP]    = cmp_q;
      bus_rdata[SB_WERR]   = werr_q;
    end else if (sel_samp) begin
      bus_rdata[CNT_W-1:0] = en_q ? duty_q : '0;
    end else if (sel_per) begin
      bus_rdata[CNT_W-1:0] = per_q;
    end
  end

  assign pwm_out = pin_level(en_q, cnt_q < duty_q, mode_q);
endmodule

// File: rtl/pwmq_unit_chk.sv
module pwmq_unit_chk #(
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int LW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pwm_out,
  input logic              ctl_en,
  input logic [LW-1:0]     fifo_level,
  input logic              wrap_evt,
  input logic              load_evt,
  input logic              swr_busy,
  input logic [CNT_W-1:0]  cnt_q
);
  localparam logic [ADDR_W-1:0] A_SAMP = ADDR_W'(12);

  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !pwm_out);

  p_fifo_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  p_full_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SAMP && fifo_level == LW'(DEPTH) && !load_evt && !swr_busy)
    |=> fifo_level == LW'(DEPTH));

  p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cnt_q == '0);

  p_swr_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swr_busy |=> (fifo_level == '0 && !ctl_en));

  p_hidden_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && bus_addr == A_SAMP) |-> bus_rdata == '0);

  p_start_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> cnt_q == '0);
endmodule

bind pwmq_unit pwmq_unit_chk #(
  .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LW(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pwm_out(pwm_out), .ctl_en(en_q),
  .fifo_level(fifo_level), .wrap_evt(wrap_evt), .load_evt(load_evt),
  .swr_busy(swr_busy), .cnt_q(cnt_q)
);

// File: tb/pwmq_unit_test.sv
module pwmq_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int RSTC  = 4;
  localparam int A_CTRL = 0, A_STAT = 4, A_SAMP = 12, A_PER = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  pwmq_unit uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, misses = 0;
  string phase = "R1";
  bit done = 0;
  bit tick_all = 1;
  int tdiv = 0, rot = 0;

  // behavioural reference state
  int m_en, m_rpt, m_psc, m_src, m_mode, m_per, m_duty;
  int m_cnt, m_pc, m_rc, m_roll, m_cmp, m_werr, m_swr;
  int mq[$];

  task automatic m_clear();
    m_en = 0; m_rpt = 0; m_psc = 0; m_src = 0; m_mode = 0; m_per = 0; m_duty = 0;
    m_cnt = 0; m_pc = 0; m_rc = 0; m_roll = 0; m_cmp = 0; m_werr = 0;
    mq.delete();
  endtask

  initial begin m_clear(); m_swr = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear(); m_swr = 0;
    end else if (m_swr > 0) begin
      m_clear(); m_swr--;
    end else begin
      bit full, running, tk, wr, hit, adv;
      int top, a, d;
      a = int'(bus_addr); d = int'(bus_wdata);
      full    = (mq.size() == DEPTH);
      running = (m_en != 0) && (m_src != 0);
      tk      = running && tick_en && (m_pc == m_psc);
      top     = ((m_per >= 65535) ? 65534 : m_per) + 1;
      wr      = tk && (m_cnt == top);
      hit     = tk && (m_cnt == m_duty);
      adv     = wr && (m_rc == (1 << m_rpt) - 1);
      if (!running) m_pc = 0;
      else if (tick_en) m_pc = (m_pc == m_psc) ? 0 : (m_pc + 1) % 4096;
      if (m_en == 0) begin m_cnt = 0; m_rc = 0; end
      else begin
        if (tk) m_cnt = wr ? 0 : (m_cnt + 1) % 65536;
        if (wr) m_rc = adv ? 0 : (m_rc + 1) % 8;
      end
      if (adv && mq.size() > 0) m_duty = mq.pop_front();
      if (bus_we && a == A_STAT) begin
        if (d[4]) m_roll = 0;
        if (d[5]) m_cmp = 0;
        if (d[6]) m_werr = 0;
      end
      if (wr)  m_roll = 1;
      if (hit) m_cmp = 1;
      if (bus_we && a == A_SAMP) begin
        if (full) m_werr = 1; else mq.push_back(d & 32'hFFFF);
      end
      if (bus_we && a == A_PER) m_per = d & 32'hFFFF;
      if (bus_we && a == A_CTRL) begin
        if (d[3]) begin
          m_clear(); m_swr = RSTC;
        end else begin
          if (d[0] && m_en == 0 && mq.size() > 0) m_duty = mq.pop_front();
          m_en = d & 1; m_rpt = (d >> 1) & 3; m_psc = (d >> 4) & 12'hFFF;
          m_src = (d >> 16) & 3; m_mode = (d >> 18) & 3;
        end
      end
    end
  end

  function automatic int exp_read(int a);
    case (a)
      A_CTRL: return m_en | (m_rpt << 1) | ((m_swr > 0) << 3) | (m_psc << 4) | (m_src << 16) | (m_mode << 18);
      A_STAT: return mq.size() | ((mq.size() == 0) << 3) | (m_roll << 4) | (m_cmp << 5) | (m_werr << 6);
      A_SAMP: return (m_en != 0) ? m_duty : 0;
      A_PER:  return m_per;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_out();
    bit below;
    below = (m_cnt < m_duty);
    return (m_en != 0) && (m_mode < 2) && (below ^ (m_mode == 1));
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      int er;
      vectors++;
      if (pwm_out !== exp_out()) begin
        misses++;
        $display("FAIL %s pwm_out actual=%0b expected=%0b t=%0t", phase, pwm_out, exp_out(), $time);
      end
      er = exp_read(int'(bus_addr));
      vectors++;
      if (bus_rdata !== 32'(er)) begin
        misses++;
        $display("FAIL %s rdata@%0h actual=%0h expected=%0h t=%0t", phase, bus_addr, bus_rdata, er, $time);
      end
    end
  end

  task automatic drive_tick();
    tick_en = tick_all ? 1'b1 : (tdiv == 0);
    tdiv = (tdiv + 1) % 3;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      bus_we = 1'b0;
      case (rot % 4)
        0: bus_addr = 5'(A_CTRL);
        1: bus_addr = 5'(A_STAT);
        2: bus_addr = 5'(A_SAMP);
        default: bus_addr = 5'(A_PER);
      endcase
      rot++;
      drive_tick();
    end
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = 32'(d);
    drive_tick();
    idle(1);
  endtask

  localparam int RUN = 1, SRC1 = 1 << 16;

  initial begin
    // R1: reset values and register layout
    idle(3);
    @(posedge clk); #1; rst_n = 1'b1;
    phase = "R1";
    idle(8);
    wr(A_PER, 3);
    wr(A_CTRL, SRC1 | (5 << 4) | (2 << 1) | (1 << 18));
    idle(4);
    wr(A_CTRL, SRC1);
    wr(8, 32'hFFFF);
    @(posedge clk); #1; bus_addr = 5'd8; idle(0);
    idle(4);
    // R6: queue depth and empty flag
    phase = "R6";
    wr(A_SAMP, 1); idle(2); wr(A_SAMP, 2); idle(2); wr(A_SAMP, 3); idle(4);
    // R7: overflow drop and sticky error with clear
    phase = "R7";
    wr(A_SAMP, 4); wr(A_SAMP, 5); idle(4);
    wr(A_STAT, 32'h40); idle(4);
    // R12: enable restart with immediate load
    phase = "R12";
    wr(A_CTRL, SRC1 | RUN); idle(30);
    // R10: repeat codes and queue refill near period ends
    phase = "R10";
    wr(A_CTRL, SRC1 | RUN | (1 << 1));
    for (int k = 0; k < 12; k++) begin wr(A_SAMP, k % 6); idle(k % 5); end
    idle(60);
    wr(A_CTRL, SRC1 | RUN | (3 << 1)); wr(A_SAMP, 2); idle(100);
    wr(A_CTRL, SRC1 | RUN | (2 << 1)); idle(50);
    // R11: sticky events and their clear
    phase = "R11";
    wr(A_STAT, 32'h70); idle(3); wr(A_STAT, 32'h10); idle(20);
    // R3: output modes
    phase = "R3";
    wr(A_CTRL, SRC1 | RUN | (1 << 18)); wr(A_SAMP, 3); wr(A_SAMP, 1); idle(30);
    wr(A_CTRL, SRC1 | RUN | (2 << 18)); idle(20);
    wr(A_CTRL, SRC1 | RUN | (3 << 18)); idle(10);
    wr(A_CTRL, SRC1 | RUN); wr(A_SAMP, 5); idle(20);
    // R5: prescaler with sparse strobe, then source off
    phase = "R5";
    tick_all = 0;
    wr(A_CTRL, SRC1 | RUN | (2 << 4)); wr(A_SAMP, 2); idle(150);
    wr(A_CTRL, RUN | (2 << 4)); idle(30);
    tick_all = 1;
    // R2: shortest period, then saturated top code
    phase = "R2";
    wr(A_CTRL, SRC1); wr(A_PER, 0); wr(A_SAMP, 1);
    wr(A_CTRL, SRC1 | RUN); idle(20);
    wr(A_PER, 32'hFFFE); wr(A_SAMP, 100); idle(300);
    wr(A_PER, 32'hFFFF); idle(66000);
    // R4 and R9: stopped output and hidden sample
    phase = "R4";
    wr(A_CTRL, SRC1 | (1 << 18)); idle(20);
    phase = "R9";
    wr(A_SAMP, 9); idle(8);
    // R8: software reset, writes ignored while it runs
    phase = "R8";
    wr(A_CTRL, SRC1 | RUN); idle(4);
    wr(A_CTRL, 8); idle(10);
    wr(A_SAMP, 7); idle(4);
    wr(A_CTRL, 8); wr(A_CTRL, SRC1 | RUN); wr(A_SAMP, 6); idle(10);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL %s watchdog actual=running expected=finished", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule